// File: doc/BRIEF.md
# DMA Interrupt Signaling Unit

This block gathers per-channel interrupt events from a group of DMA channels and reports them to the host on one of two paths. The first path is a dedicated active-high interrupt pin. The second is a message-signaled interrupt, sent upstream as a posted memory write through a simple request/ready handshake. The MSI enable bit picks the path, so software does not switch anything else.

A register port gives software access to four 32-bit words:

| Offset | Register |
|---|---|
| 0 | Control: enable bit and message-count field |
| 1 | Message address |
| 2 | Message data |
| 3 | Global pending-status word, write-one-to-clear |

One message register set serves every channel. On the message path, abort events can be told apart from normal completion events (end of transfer, end of chain, stop, suspend). The legacy pin cannot make this distinction. The service routine reads the status word before it exits, to confirm that no new event arrived while it was running. Only edge-style messages are produced, and there is no end-of-interrupt return path.

Top module: `dma_irq_signal`

## Requirements
- R1: After reset, the control, data and status words read 0, the address word reads 0xFEE00000, and `irq_pin` and `mw_req` are low.
- R2: A write to the address word (offset 1) takes effect only when bits 31:20 of the written value equal 0xFEE. Any other value leaves the word unchanged.
- R3: A pulse on `evt_norm[i]` sets status bit i. A pulse on `evt_abort[i]` sets status bit NCH+i. Writing a one to a status bit (offset 3) clears it. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: When control bit 0 (message enable) is 0, `irq_pin` is high exactly while some status bit is set. When the enable bit is 1, `irq_pin` stays low.
- R5: With control bit 0 set, each cycle that has at least one abort pulse queues one abort message, and each cycle that has at least one normal pulse queues one normal message. Every queued message becomes one `mw_req` transfer. With the enable bit clear, no transfers are made.
- R6: `mw_addr` carries the address word. When control bits 3:1 are nonzero (two messages allowed), `mw_data` is the data word with bit 0 forced to 1 for an abort message and to 0 for a normal message. When those bits are zero, `mw_data` is the data word unchanged.
- R7: When abort messages and normal messages are both waiting, an abort message is sent first.
- R8: While `mw_req` is high and `mw_ready` is low, `mw_req`, `mw_addr` and `mw_data` hold their values.
- R9: Pulses that arrive while a transfer is stalled are counted, and each one later produces its own transfer. Up to 2^CW-1 messages can wait per class.
- R10: Clearing the enable bit discards the queued messages that have not yet been sent. A transfer that is already being requested still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_norm | input | NCH | Per-channel normal-completion event pulses |
| evt_abort | input | NCH | Per-channel abort event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_pin | output | 1 | Legacy active-high interrupt level |
| mw_req | output | 1 | Upstream memory-write request |
| mw_addr | output | 32 | Memory-write address |
| mw_data | output | 32 | Memory-write data |
| mw_ready | input | 1 | Upstream accepts the write when high together with `mw_req` |

## Verification
The hardest situations to reach from the ports involve messages waiting behind a stalled transfer. Examples are several normal pulses that must all come out later, or a disable that must discard exactly the backlog and no more. The bench holds `mw_ready` low on purpose while it sends pulses in separate cycles. It then releases `mw_ready` and compares every transfer against a scoreboard of expected address/data pairs. The bench also sends abort and normal pulses in the same cycle to check that the two classes come out in the right order with the right encoding. Finally, it drives a channel pulse in the same cycle as a clear of that channel's status bit.

// File: rtl/dma_irq_signal.sv
module dma_irq_signal #(
  parameter int NCH = 4,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_norm,
  input  logic [NCH-1:0] evt_abort,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq_pin,
  output logic           mw_req,
  output logic [31:0]    mw_addr,
  output logic [31:0]    mw_data,
  input  logic           mw_ready
);
  localparam int SW = 2 * NCH;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [31:0] ADDR_RST = 32'hFEE0_0000;

  logic          msi_en;
  logic [2:0]    mme;
  logic [31:0]   addr_q, data_q;
  logic [SW-1:0] stat_q;
  logic [CW-1:0] a_cnt, n_cnt;
  logic          req_q;
  logic [31:0]   req_addr, req_data;

  wire wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire wr_addr = reg_wr && reg_addr == 2'd1;
  wire wr_data = reg_wr && reg_addr == 2'd2;
  wire wr_stat = reg_wr && reg_addr == 2'd3;

  wire two_msg = mme != 3'd0;
  wire hit_a   = msi_en && (|evt_abort);
  wire hit_n   = msi_en && (|evt_norm);
  wire pick_a  = a_cnt != '0;
  wire load    = msi_en && !req_q && (pick_a || n_cnt != '0);
  wire dec_a   = load && pick_a;
  wire dec_n   = load && !pick_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en <= 1'b0;
      mme    <= 3'd0;
      addr_q <= ADDR_RST;
      data_q <= 32'd0;
    end else begin
      if (wr_ctrl) begin
        msi_en <= reg_wdata[0];
        mme    <= reg_wdata[3:1];
      end
      if (wr_addr && reg_wdata[31:20] == 12'hFEE) addr_q <= reg_wdata;
      if (wr_data) data_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else stat_q <= (stat_q & ~(wr_stat ? reg_wdata[SW-1:0] : '0)) | {evt_abort, evt_norm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
      n_cnt <= '0;
    end else if (!msi_en) begin
      a_cnt <= '0;
      n_cnt <= '0;
    end else begin
      if (hit_a && !dec_a && a_cnt != CMAX) a_cnt <= a_cnt + 1'b1;
      else if (!hit_a && dec_a)             a_cnt <= a_cnt - 1'b1;
      if (hit_n && !dec_n && n_cnt != CMAX) n_cnt <= n_cnt + 1'b1;
      else if (!hit_n && dec_n)             n_cnt <= n_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      req_addr <= 32'd0;
      req_data <= 32'd0;
    end else if (load) begin
      req_q    <= 1'b1;
      req_addr <= addr_q;
      req_data <= two_msg ? {data_q[31:1], pick_a} : data_q;
    end else if (req_q && mw_ready) begin
      req_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, mme, msi_en};
      2'd1:    reg_rdata = addr_q;
      2'd2:    reg_rdata = data_q;
      default: reg_rdata = 32'(stat_q);
    endcase
  end

  assign irq_pin = !msi_en && (|stat_q);
  assign mw_req  = req_q;
  assign mw_addr = req_addr;
  assign mw_data = req_data;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && !mw_ready |=> mw_req && $stable(mw_addr) && $stable(mw_data));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[31:20] == 12'hFEE);

  p_msg_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_req) |-> $past(msi_en));

  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|{evt_abort, evt_norm}) |=>
      ((stat_q & $past({evt_abort, evt_norm})) == $past({evt_abort, evt_norm})));

  p_abort_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_req) && $past(two_msg && a_cnt != '0) |-> mw_data[0]);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_cnt == CMAX |-> !hit_a);
endmodule

// File: tb/dma_irq_signal_bench.sv
module dma_irq_signal_bench;
  localparam int NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] evt_norm = '0, evt_abort = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata, mw_addr, mw_data;
  logic irq_pin, mw_req, mw_ready = 1'b0;
  logic hold = 1'b0;
  int checks = 0, failures = 0, cyc = 0;
  logic [63:0] sb[$];

  always #10 clk = ~clk;

  dma_irq_signal #(.NCH(NCH), .CW(4)) u_dma_irq_signal (
    .clk(clk), .rst_n(rst_n), .evt_norm(evt_norm), .evt_abort(evt_abort),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_ready(mw_ready));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    mw_ready <= !hold && (cyc % 3 != 1);
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && mw_req && mw_ready) begin
      if (sb.size() == 0) chk(0, "R5 unexpected transfer", {mw_addr, mw_data}, 64'd0);
      else begin
        logic [63:0] e;
        e = sb.pop_front();
        chk({mw_addr, mw_data} == e, "R6 transfer", {mw_addr, mw_data}, e);
      end
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] n, input logic [NCH-1:0] ab);
    @(negedge clk);
    evt_norm = n; evt_abort = ab;
    @(negedge clk);
    evt_norm = '0; evt_abort = '0;
  endtask

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    chk(sb.size() == 0, tag, 64'(sb.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rreg(2'd1, v); chk(v == 32'hFEE00000, "R1 addr", v, 32'hFEE00000);
    rreg(2'd2, v); chk(v == 0, "R1 data", v, 0);
    rreg(2'd3, v); chk(v == 0, "R1 status", v, 0);
    chk(!irq_pin && !mw_req, "R1 outputs", {irq_pin, mw_req}, 0);

    wreg(2'd1, 32'h1234_5678);
    rreg(2'd1, v); chk(v == 32'hFEE00000, "R2 reject", v, 32'hFEE00000);
    wreg(2'd1, 32'hFEE0_1234);
    rreg(2'd1, v); chk(v == 32'hFEE01234, "R2 accept", v, 32'hFEE01234);

    pulse(4'b0010, 4'b0000);
    rreg(2'd3, v); chk(v == 32'h02, "R3 normal set", v, 32'h02);
    chk(irq_pin, "R4 pin high", irq_pin, 1);
    pulse(4'b0000, 4'b0100);
    rreg(2'd3, v); chk(v == 32'h42, "R3 abort set", v, 32'h42);
    wreg(2'd3, 32'h02);
    rreg(2'd3, v); chk(v == 32'h40, "R3 w1c", v, 32'h40);
    chk(irq_pin, "R4 pin still high", irq_pin, 1);
    @(negedge clk);
    evt_norm = 4'b0001; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h01;
    @(negedge clk);
    evt_norm = '0; reg_wr = 1'b0;
    rreg(2'd3, v); chk(v == 32'h41, "R3 set wins", v, 32'h41);
    wreg(2'd3, 32'hFF);
    rreg(2'd3, v); chk(v == 0, "R3 clear all", v, 0);
    chk(!irq_pin, "R4 pin low", irq_pin, 0);
    drain("R5 no transfer while disabled");

    wreg(2'd2, 32'h0000_1230);
    wreg(2'd0, 32'h1);
    sb.push_back({32'hFEE01234, 32'h1230});
    sb.push_back({32'hFEE01234, 32'h1230});
    pulse(4'b1000, 4'b0001);
    @(negedge clk);
    chk(!irq_pin, "R4 pin low with message path", irq_pin, 0);
    drain("R5 single-message pair");
    wreg(2'd3, 32'hFF);

    wreg(2'd0, 32'h3);
    sb.push_back({32'hFEE01234, 32'h1231});
    sb.push_back({32'hFEE01234, 32'h1230});
    pulse(4'b0100, 4'b0010);
    drain("R7 abort then normal");

    hold = 1'b1;
    repeat (3) begin
      sb.push_back({32'hFEE01234, 32'h1230});
      pulse(4'b0001, 4'b0000);
    end
    repeat (5) @(negedge clk);
    #2 chk(mw_req, "R8 request held", mw_req, 1);
    chk(mw_data == 32'h1230, "R8 data held", mw_data, 32'h1230);
    hold = 1'b0;
    drain("R9 backlog delivered");

    hold = 1'b1;
    sb.push_back({32'hFEE01234, 32'h1230});
    pulse(4'b0010, 4'b0000);
    pulse(4'b0010, 4'b0000);
    pulse(4'b0010, 4'b0000);
    repeat (3) @(negedge clk);
    wreg(2'd0, 32'h0);
    hold = 1'b0;
    drain("R10 backlog discarded");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule